// File: doc/BRIEF.md
# Traffic Phase Controller with Illegal-Code Recovery

This block sequences the signal phases of one intersection. A finite state machine steps through idle, green, yellow and red, counting a configurable number of ticks in each phase from a one-cycle `tick_i` strobe. The current phase code and a three-lamp pattern come straight out of the state register.

Every phase change is also written into a separate level register. This write does not go straight to the register. It passes through a two-stage synchronizer and then waits out a fixed separation delay before it commits. After a commit, the level is reported as unsettled for a fixed number of cycles. The same path also accepts writes from outside the block. A validity checker watches the level register. If the register ever holds a code outside the legal set, the state machine is forced to idle and an idle code is sent down the write path, so the register returns to a legal value.

A brownout input freezes the whole block while it is high. The first clock after it falls applies a full synchronous reset, which returns the controller to its reset state.

Top module: `tpc_ctrl`

## Requirements
- R1: Phases run in the order idle (code 3'b000), green (3'b001), yellow (3'b010), red (3'b100), then back to idle. `phase_o` always shows the current code.
- R2: A phase lasts a fixed number of ticks: idle 2, green 30, yellow 4, red 34. A tick counts only when `tick_i` is high at a clock edge. The phase changes at the edge that samples the final tick, and the tick count restarts from zero in the new phase.
- R3: `lamp_o` is {red, yellow, green}. It is 3'b001 in green, 3'b010 in yellow, and 3'b100 in both red and idle.
- R4: Each phase change sends the new code to the level register. The code appears on `level_o` 66 edges after the edge that made the change (2 synchronizer stages plus a 64-cycle separation). A request that leaves the synchronizer before an earlier one commits replaces it and restarts the separation.
- R5: `ext_we_i` with `ext_code_i` writes the level register through the same path, with the same 66-edge delay. If an internal write happens on the same edge, the internal write wins and the external one is dropped.
- R6: `level_stable_o` is high after reset. It goes low at each commit and stays low for 16 cycles, then goes high again.
- R7: Any level code other than 000, 001, 010 or 100 forces the phase to idle at the next edge, with the tick count at zero. The phase holds idle while the code stays illegal. One idle-code write is launched when the code first becomes illegal, so `level_o` returns to 3'b000 66 edges later.
- R8: While `brown_i` is high at an edge, the phase, tick count and level path all hold their values. Ticks have no effect during this time.
- R9: The first edge with `brown_i` low after it was high returns the block to its reset state: phase idle, tick count zero, level 3'b000, `level_stable_o` high. Any write still in flight is discarded.
- R10: `rst_ni` is asynchronous and active low. After it rises, the block leaves reset at the third clock edge. The reset state is phase 3'b000, lamps 3'b100, level 3'b000 and stable high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle time-unit strobe for the phase timer |
| brown_i | input | 1 | Brownout indication: freezes the block; falling edge triggers reset |
| ext_we_i | input | 1 | External write request to the level register |
| ext_code_i | input | 3 | Code for the external level write |
| phase_o | output | 3 | Current phase code |
| lamp_o | output | 3 | Lamp drive {red, yellow, green} |
| level_o | output | 3 | Committed level register code |
| level_stable_o | output | 1 | Level has settled since the last commit |

## Verification
Phase and lamp outputs change at the same edge that samples the final tick of a phase. A level write shows up 66 edges after the edge that sampled it, and `level_stable_o` recovers 16 edges after that. A forced idle follows an illegal commit by one edge, and a recovery reset follows the falling edge of `brown_i` by one edge. A cycle model in the bench steps at each rising edge with these latencies and queues one expected record per edge, and a monitor compares that record against the outputs at the following falling edge. Directed checks wait an exact number of falling edges after each stimulus (67 for a level commit, 68 for a forced idle, 134 for the idle rewrite) and then compare.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  localparam int CODE_W = 3;

  typedef enum logic [CODE_W-1:0] {
    PH_IDLE   = 3'b000,
    PH_GREEN  = 3'b001,
    PH_YELLOW = 3'b010,
    PH_RED    = 3'b100
  } phase_e;

  // Lamp vector ordering: {red, yellow, green}
  localparam logic [2:0] LAMP_RED = 3'b100;
  localparam logic [2:0] LAMP_YEL = 3'b010;
  localparam logic [2:0] LAMP_GRN = 3'b001;

  function automatic phase_e phase_after(input phase_e cur);
    phase_e nxt;
    case (cur)
      PH_IDLE:   nxt = PH_GREEN;
      PH_GREEN:  nxt = PH_YELLOW;
      PH_YELLOW: nxt = PH_RED;
      default:   nxt = PH_IDLE;
    endcase
    return nxt;
  endfunction

  function automatic logic [2:0] lamp_of(input phase_e cur);
    logic [2:0] l;
    case (cur)
      PH_GREEN:  l = LAMP_GRN;
      PH_YELLOW: l = LAMP_YEL;
      default:   l = LAMP_RED;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/tpc_rst_sync.sv
module tpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/tpc_code_check.sv
module tpc_code_check #(
  parameter int CODE_W = 3
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              legal_o
);

  // Legal set: all-zero (idle) or exactly one bit set (a lit phase)
  logic [CODE_W:0] hit;

  assign hit[CODE_W] = (code_i == '0);

  for (genvar b = 0; b < CODE_W; b++) begin : g_hit
    localparam logic [CODE_W-1:0] ONE_HOT = CODE_W'(1) << b;
    assign hit[b] = (code_i == ONE_HOT);
  end

  assign legal_o = |hit;

endmodule

// File: rtl/tpc_level_path.sv
module tpc_level_path #(
  parameter int CODE_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int SEP_CYC     = 64,
  parameter int SETTLE_CYC  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cen_i,
  input  logic              clr_i,
  input  logic              wr_en_i,
  input  logic [CODE_W-1:0] wr_code_i,
  output logic [CODE_W-1:0] level_o,
  output logic              stable_o
);

  localparam int SEP_W = $clog2(SEP_CYC + 1);
  localparam int SET_W = $clog2(SETTLE_CYC + 1);

  // Synchronizer chain
  logic [SYNC_STAGES:0] stg_v;
  logic [CODE_W-1:0]    stg_c [SYNC_STAGES+1];

  assign stg_v[0] = wr_en_i;
  assign stg_c[0] = wr_code_i;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stg
    logic              v_q;
    logic [CODE_W-1:0] c_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else if (clr_i) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else if (cen_i) begin
        v_q <= stg_v[g];
        c_q <= stg_c[g];
      end
    end

    assign stg_v[g+1] = v_q;
    assign stg_c[g+1] = c_q;
  end

  // Separation hold, commit and settle tracking
  logic [CODE_W-1:0] pend_q, pend_n;
  logic              pend_v_q, pend_v_n;
  logic [SEP_W-1:0]  sep_q, sep_n;
  logic [CODE_W-1:0] lvl_q, lvl_n;
  logic [SET_W-1:0]  settle_q, settle_n;
  logic              commit;

  always_comb begin
    pend_n   = pend_q;
    pend_v_n = pend_v_q;
    sep_n    = sep_q;
    lvl_n    = lvl_q;
    settle_n = settle_q;
    commit   = 1'b0;
    if (stg_v[SYNC_STAGES]) begin
      pend_n   = stg_c[SYNC_STAGES];
      pend_v_n = 1'b1;
      sep_n    = SEP_W'(SEP_CYC - 1);
    end else if (pend_v_q) begin
      if (sep_q == '0) begin
        commit   = 1'b1;
        lvl_n    = pend_q;
        pend_v_n = 1'b0;
      end else begin
        sep_n = sep_q - 1'b1;
      end
    end
    if (commit) begin
      settle_n = SET_W'(SETTLE_CYC);
    end else if (settle_q != '0) begin
      settle_n = settle_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      sep_q    <= '0;
      lvl_q    <= '0;
      settle_q <= '0;
    end else if (clr_i) begin
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      sep_q    <= '0;
      lvl_q    <= '0;
      settle_q <= '0;
    end else if (cen_i) begin
      pend_q   <= pend_n;
      pend_v_q <= pend_v_n;
      sep_q    <= sep_n;
      lvl_q    <= lvl_n;
      settle_q <= settle_n;
    end
  end

  assign level_o  = lvl_q;
  assign stable_o = (settle_q == '0);

  // R4
  level_chg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past((commit && cen_i) || clr_i));

  // R6
  settle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && cen_i && !clr_i) |=> !stable_o);

  // R9
  clr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (lvl_q == '0) && stable_o && !pend_v_q);

endmodule

// File: rtl/tpc_ctrl.sv
module tpc_ctrl
  import tpc_pkg::*;
#(
  parameter int IDLE_TICKS   = 2,
  parameter int GREEN_TICKS  = 30,
  parameter int YELLOW_TICKS = 4,
  parameter int RED_TICKS    = 34,
  parameter int SYNC_STAGES  = 2,
  parameter int SEP_CYC      = 64,
  parameter int SETTLE_CYC   = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       brown_i,
  input  logic       ext_we_i,
  input  logic [2:0] ext_code_i,
  output logic [2:0] phase_o,
  output logic [2:0] lamp_o,
  output logic [2:0] level_o,
  output logic       level_stable_o
);

  localparam int MAX_A     = (IDLE_TICKS > GREEN_TICKS) ? IDLE_TICKS : GREEN_TICKS;
  localparam int MAX_B     = (YELLOW_TICKS > RED_TICKS) ? YELLOW_TICKS : RED_TICKS;
  localparam int MAX_TICKS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TMR_W     = $clog2(MAX_TICKS + 1);

  logic rst_n;

  tpc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i  (clk_i),
    .arst_ni(rst_ni),
    .rst_no (rst_n)
  );

  // Brownout edge tracking
  logic brown_q;
  logic recover;
  logic cen;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      brown_q <= 1'b0;
    end else begin
      brown_q <= brown_i;
    end
  end

  assign recover = brown_q & ~brown_i;
  assign cen     = ~brown_i;

  // Validity checks on the level register and the state register
  phase_e            state_q, state_n;
  logic [TMR_W-1:0]  timer_q, timer_n;
  logic              ill_q;
  logic [CODE_W-1:0] level_w;
  logic              lvl_ok, st_ok, illegal;

  tpc_code_check #(.CODE_W(CODE_W)) u_lvl_chk (
    .code_i (level_w),
    .legal_o(lvl_ok)
  );

  tpc_code_check #(.CODE_W(CODE_W)) u_st_chk (
    .code_i (state_q),
    .legal_o(st_ok)
  );

  assign illegal = ~lvl_ok | ~st_ok;

  // Phase duration lookup
  logic [TMR_W-1:0] last_cnt;

  always_comb begin
    case (state_q)
      PH_GREEN:  last_cnt = TMR_W'(GREEN_TICKS - 1);
      PH_YELLOW: last_cnt = TMR_W'(YELLOW_TICKS - 1);
      PH_RED:    last_cnt = TMR_W'(RED_TICKS - 1);
      default:   last_cnt = TMR_W'(IDLE_TICKS - 1);
    endcase
  end

  // Next-state logic
  always_comb begin
    state_n = state_q;
    timer_n = timer_q;
    if (illegal) begin
      state_n = PH_IDLE;
      timer_n = '0;
    end else if (tick_i) begin
      if (timer_q == last_cnt) begin
        state_n = phase_after(state_q);
        timer_n = '0;
      end else begin
        timer_n = timer_q + 1'b1;
      end
    end
  end

  // Level write request: phase change or first cycle of an illegal code
  logic              int_wr;
  logic              wr_en;
  logic [CODE_W-1:0] wr_code;

  assign int_wr  = (state_n != state_q) | (illegal & ~ill_q);
  assign wr_en   = int_wr | ext_we_i;
  assign wr_code = int_wr ? CODE_W'(state_n) : ext_code_i;

  // State registers
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      timer_q <= '0;
      ill_q   <= 1'b0;
    end else if (recover) begin
      state_q <= PH_IDLE;
      timer_q <= '0;
      ill_q   <= 1'b0;
    end else if (cen) begin
      state_q <= state_n;
      timer_q <= timer_n;
      ill_q   <= illegal;
    end
  end

  tpc_level_path #(
    .CODE_W     (CODE_W),
    .SYNC_STAGES(SYNC_STAGES),
    .SEP_CYC    (SEP_CYC),
    .SETTLE_CYC (SETTLE_CYC)
  ) u_lvl (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cen_i    (cen),
    .clr_i    (recover),
    .wr_en_i  (wr_en),
    .wr_code_i(wr_code),
    .level_o  (level_w),
    .stable_o (level_stable_o)
  );

  assign phase_o = state_q;
  assign lamp_o  = lamp_of(state_q);
  assign level_o = level_w;

  // R1
  phase_code_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0(phase_o));

  // R2
  timer_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    timer_q <= last_cnt);

  // R7
  force_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!lvl_ok && !brown_i) |=> (phase_o == 3'b000) && (timer_q == '0));

  // R8
  freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    brown_i |=> $stable(phase_o) && $stable(timer_q) && $stable(level_o));

  // R9
  recover_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    (brown_q && !brown_i) |=> (phase_o == 3'b000) && (timer_q == '0));

endmodule

// File: tb/tpc_ctrl_tb.sv
`timescale 1ns/1ps
module tpc_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tick = 1'b0;
  logic       brown = 1'b0;
  logic       ext_we = 1'b0;
  logic [2:0] ext_code = 3'b000;
  logic [2:0] phase, lamp, level;
  logic       stable;

  always #2.5 clk = ~clk;

  tpc_ctrl u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .tick_i        (tick),
    .brown_i       (brown),
    .ext_we_i      (ext_we),
    .ext_code_i    (ext_code),
    .phase_o       (phase),
    .lamp_o        (lamp),
    .level_o       (level),
    .level_stable_o(stable)
  );

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done  = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int nxt_code(input int c);
    case (c)
      0: return 1;
      1: return 2;
      2: return 4;
      default: return 0;
    endcase
  endfunction

  function automatic int dur_of(input int c);
    case (c)
      1: return 30;
      2: return 4;
      4: return 34;
      default: return 2;
    endcase
  endfunction

  function automatic int lamp_exp(input int c);
    if (c == 1) return 1;
    if (c == 2) return 2;
    return 4;
  endfunction

  // ---------------- cycle model (scoreboard producer) ----------------
  typedef struct packed {
    logic [2:0] ph;
    logic [2:0] lp;
    logic [2:0] lv;
    logic       st;
  } exp_t;

  exp_t exp_q[$];

  int m_rs = 0, m_bq = 0;
  int m_st = 0, m_tm = 0, m_ill = 0;
  int s1v = 0, s1c = 0, s2v = 0, s2c = 0;
  int pv = 0, pc = 0, sep = 0, lvl = 0, settle = 0;

  task automatic m_clear();
    m_st = 0; m_tm = 0; m_ill = 0;
    s1v = 0; s1c = 0; s2v = 0; s2c = 0;
    pv = 0; pc = 0; sep = 0; lvl = 0; settle = 0;
  endtask

  task automatic m_step();
    int bad, st_n, tm_n, iw, wv, wc, commit;
    bad  = !(lvl == 0 || lvl == 1 || lvl == 2 || lvl == 4);
    st_n = m_st;
    tm_n = m_tm;
    if (bad) begin
      st_n = 0; tm_n = 0;
    end else if (tick) begin
      if (m_tm == dur_of(m_st) - 1) begin st_n = nxt_code(m_st); tm_n = 0; end
      else tm_n = m_tm + 1;
    end
    iw = (st_n != m_st) || (bad && !m_ill);
    wv = iw || ext_we;
    wc = iw ? st_n : int'(ext_code);
    commit = 0;
    if (s2v) begin pc = s2c; pv = 1; sep = 63; end
    else if (pv) begin
      if (sep == 0) begin commit = 1; lvl = pc; pv = 0; end
      else sep = sep - 1;
    end
    if (commit) settle = 16;
    else if (settle != 0) settle = settle - 1;
    s2v = s1v; s2c = s1c; s1v = wv; s1c = wc;
    m_ill = bad; m_st = st_n; m_tm = tm_n;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rs = 0; m_bq = 0; m_clear();
    end else if (m_rs < 2) begin
      m_rs++; m_bq = 0; m_clear();
    end else begin
      if (m_bq && !brown) m_clear();
      else if (!brown) m_step();
      m_bq = brown;
    end
    exp_q.push_back('{3'(m_st), 3'(lamp_exp(m_st)), 3'(lvl), (settle == 0)});
  end

  // ---------------- monitor (scoreboard consumer) ----------------
  always @(negedge clk) begin
    exp_t e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk("R2", "phase vs model", phase, e.ph);
      chk("R3", "lamps vs model", lamp, e.lp);
      chk("R4", "level vs model", level, e.lv);
      chk("R6", "stable vs model", stable, e.st);
    end
  end

  // ---------------- driver ----------------
  task automatic run(input int n, input int div, input bit watch);
    int last, held;
    last = phase;
    held = -1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (held >= 0) held++;
      if (watch && phase != last) begin
        chk("R1", "phase order", phase, nxt_code(last));
        chk("R3", "lamp on change", lamp, lamp_exp(phase));
        if (div == 1 && held >= 0) chk("R2", "phase length", held, dur_of(last));
        held = 0;
      end
      last = phase;
      if (div > 0) tick = ((i % div) == 0);
      else if (div < 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick = lfsr[0] | lfsr[5];
      end else tick = 1'b0;
    end
  endtask

  task automatic go_green();
    forever begin
      @(negedge clk);
      if (phase == 3'b001) begin tick = 1'b0; break; end
      tick = 1'b1;
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int ph0, lv0;
    #1 rst_n = 1'b0;
    wait_neg(3);
    // R10 reset state
    chk("R10", "reset phase", phase, 0);
    chk("R10", "reset lamps", lamp, 4);
    chk("R10", "reset level", level, 0);
    chk("R10", "reset stable", stable, 1);
    rst_n = 1'b1;
    wait_neg(2);
    chk("R10", "held during release", phase, 0);

    run(600, 4, 1);
    run(160, 1, 1);
    run(700, -1, 1);

    // R4 / R6: level settles to green with ticks stopped
    go_green();
    run(100, 0, 0);
    chk("R4", "level after green commit", level, 1);
    chk("R6", "stable after settle", stable, 1);

    // R5 / R7: inject an illegal code
    ext_we = 1'b1; ext_code = 3'b101;
    @(negedge clk);
    ext_we = 1'b0;
    wait_neg(66);
    chk("R5", "external code committed", level, 5);
    chk("R6", "unsettled after commit", stable, 0);
    chk("R7", "phase before force", phase, 1);
    wait_neg(1);
    chk("R7", "forced idle", phase, 0);
    chk("R3", "idle lamps", lamp, 4);
    wait_neg(65);
    chk("R7", "still idle while illegal", phase, 0);
    wait_neg(1);
    chk("R7", "idle code rewritten", level, 0);

    // R5 legal external write
    ext_we = 1'b1; ext_code = 3'b010;
    @(negedge clk);
    ext_we = 1'b0;
    wait_neg(66);
    chk("R5", "legal external commit", level, 2);
    wait_neg(1);
    chk("R5", "no force on legal code", phase, 0);

    // R8 / R9: brownout
    go_green();
    run(5, 1, 0);
    ph0 = phase; lv0 = level;
    brown = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      tick = ~tick;
    end
    chk("R8", "phase frozen", phase, ph0);
    chk("R8", "level frozen", level, lv0);
    brown = 1'b0; tick = 1'b0;
    @(negedge clk);
    chk("R9", "recover phase", phase, 0);
    chk("R9", "recover level", level, 0);
    chk("R9", "recover stable", stable, 1);
    wait_neg(5);
    // R5 priority: external write dropped when internal write on same edge
    tick = 1'b1; ext_we = 1'b1; ext_code = 3'b010;
    wait_neg(2);
    tick = 1'b0; ext_we = 1'b0;
    chk("R2", "idle lasts two ticks", phase, 1);
    run(100, 0, 0);
    chk("R5", "internal write wins", level, 1);
    chk("R9", "no stale pending write", stable, 1);

    run(400, 4, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule